// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data between an A side and a B side in both directions at once. Each direction has its own storage stage, and a latch-enable level selects how that stage behaves. With the enable high the stage is transparent. With it low the stage holds, or it loads new data when its own capture clock rises. Each direction also has an active-low output enable. Pins are modelled as a value plus a per-bit drive enable, so that an I/O ring outside the block can form the tri-state pads.

The data path is divided into lanes, two lanes of nine bits by default. Each lane has its own copy of all six controls: output enable, latch enable and capture clock, one set per direction. To use the lanes as one wide transceiver, tie the controls of all lanes together. To use them as independent narrow transceivers, drive each set separately.

A test-mode input hands the pins to a boundary-scan block. While it is asserted, the stored data is frozen and every output value and drive enable comes from the override inputs.

The capture clocks are ordinary data inputs. They are sampled on the block clock `clk`, and a rising edge means the clock input was sampled low at one `clk` edge and high at the next.

Top module: `bidir_store_xcvr`

## Requirements
- R1: In normal mode, while `leab` of a lane is 1, that lane's bits of `b_out` equal the same bits of `a_in` in the same cycle, with no clock edge needed.
- R2: In normal mode, while `leab` of a lane is 0 and `clkab` of that lane holds a constant level, that lane's `b_out` keeps its stored value whatever `a_in` does.
- R3: In normal mode, with `leab` 0, a `clk` edge at which `clkab` is sampled 1, after being sampled 0 at the previous edge, loads the lane's `a_in` into storage. The new value shows on `b_out` after that edge.
- R4: While `leab` is 1, storage loads `a_in` at every `clk` edge, and a rising `clkab` has no further effect. After `leab` falls, `b_out` shows the `a_in` sampled at the last edge where `leab` was 1.
- R5: In normal mode, each bit of a lane's `b_drv` is 1 when that lane's `oeab_n` is 0 and is 0 when `oeab_n` is 1. The same holds for `a_drv` with `oeba_n`.
- R6: The B-to-A direction behaves as R1 to R4 describe. It uses `b_in`, `leba`, `clkba` and `oeba_n`, and presents its result on `a_out`.
- R7: The controls of lane k act only on bits [k*LANE_W +: LANE_W]. The other lanes are not affected.
- R8: While `test_mode` is 1, `a_out`, `a_drv`, `b_out` and `b_drv` equal `tst_a_val`, `tst_a_drv`, `tst_b_val` and `tst_b_drv`, and storage does not change. After `test_mode` returns to 0, the value stored before test mode reappears.
- R9: Asynchronous reset (`rst_n` 0) clears all storage to zero and treats the capture clocks as previously low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples controls and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Data received from the A side |
| b_in | input | 18 | Data received from the B side |
| oeab_n | input | 2 | Per-lane active-low drive enable for the B side |
| oeba_n | input | 2 | Per-lane active-low drive enable for the A side |
| leab | input | 2 | Per-lane A-to-B transparency enable |
| leba | input | 2 | Per-lane B-to-A transparency enable |
| clkab | input | 2 | Per-lane A-to-B capture clock |
| clkba | input | 2 | Per-lane B-to-A capture clock |
| test_mode | input | 1 | Boundary-scan takeover of the pins |
| tst_a_val | input | 18 | Override value for the A side |
| tst_a_drv | input | 18 | Override drive enable for the A side |
| tst_b_val | input | 18 | Override value for the B side |
| tst_b_drv | input | 18 | Override drive enable for the B side |
| a_out | output | 18 | Value presented on the A side |
| a_drv | output | 18 | Drive enable for the A side |
| b_out | output | 18 | Value presented on the B side |
| b_drv | output | 18 | Drive enable for the B side |

## Verification
A capture-clock rise can arrive at the same `clk` edge as a rising or falling latch enable, or as a test-mode entry. The loaded value then depends on which rule takes precedence.

Random stimulus toggles the capture clocks, the latch enables and `test_mode` independently in every cycle, so these coincidences occur often. A directed case also raises `clkab` while `leab` is high.

Each cycle the outputs are compared with a bench model that applies the precedence stated in R3, R4 and R8. Test mode wins over any load, and transparency makes a capture edge redundant.

// File: rtl/bsx_pkg.sv
package bsx_pkg;

   typedef enum logic [1:0] {
      SM_HOLD   = 2'd0,
      SM_PASS   = 2'd1,
      SM_CAPT   = 2'd2,
      SM_FROZEN = 2'd3
   } smode_e;

   // Priority: test freeze, then transparency, then capture edge, else hold.
   function automatic smode_e pick_mode(input logic freeze, input logic le,
                                        input logic rise);
      if (freeze)    return SM_FROZEN;
      else if (le)   return SM_PASS;
      else if (rise) return SM_CAPT;
      else           return SM_HOLD;
   endfunction

endpackage

// File: rtl/bsx_store.sv
module bsx_store
   import bsx_pkg::*;
#(
   parameter int DW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] din,
   input  logic          le,
   input  logic          sclk,
   input  logic          freeze,
   output logic [DW-1:0] dout
);

   logic [DW-1:0] store;
   logic          sclk_q;
   logic          rise;
   smode_e        mode;

   assign rise = sclk & ~sclk_q;
   assign mode = pick_mode(freeze, le, rise);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store  <= '0;
         sclk_q <= 1'b0;
      end else begin
         sclk_q <= sclk;
         if (mode == SM_PASS || mode == SM_CAPT)
            store <= din;
      end
   end

   assign dout = (mode == SM_PASS) ? din : store;

   // R2
   hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && !le && !sclk) |=> $stable(store));

   // R3
   capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!freeze && !le && $rose(sclk)) |=> (store == $past(din)));

   // R8
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> $stable(store));

endmodule

// File: rtl/bsx_lane.sv
module bsx_lane #(
   parameter int LW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [LW-1:0] a_in,
   input  logic [LW-1:0] b_in,
   input  logic          oeab_n,
   input  logic          oeba_n,
   input  logic          leab,
   input  logic          leba,
   input  logic          clkab,
   input  logic          clkba,
   input  logic          test_mode,
   input  logic [LW-1:0] tst_a_val,
   input  logic [LW-1:0] tst_a_drv,
   input  logic [LW-1:0] tst_b_val,
   input  logic [LW-1:0] tst_b_drv,
   output logic [LW-1:0] a_out,
   output logic [LW-1:0] a_drv,
   output logic [LW-1:0] b_out,
   output logic [LW-1:0] b_drv
);

   logic [LW-1:0] ab_q;
   logic [LW-1:0] ba_q;

   bsx_store #(.DW(LW)) u_ab (
      .clk(clk), .rst_n(rst_n), .din(a_in), .le(leab), .sclk(clkab),
      .freeze(test_mode), .dout(ab_q)
   );

   bsx_store #(.DW(LW)) u_ba (
      .clk(clk), .rst_n(rst_n), .din(b_in), .le(leba), .sclk(clkba),
      .freeze(test_mode), .dout(ba_q)
   );

   always_comb begin
      if (test_mode) begin
         b_out = tst_b_val;
         b_drv = tst_b_drv;
         a_out = tst_a_val;
         a_drv = tst_a_drv;
      end else begin
         b_out = ab_q;
         b_drv = {LW{~oeab_n}};
         a_out = ba_q;
         a_drv = {LW{~oeba_n}};
      end
   end

   // R1
   ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && leab) |-> (b_out == a_in));

   // R6
   ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && leba) |-> (a_out == b_in));

   // R5
   ab_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && oeab_n) |-> (b_drv == '0));

   // R5
   ab_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!test_mode && !oeab_n) |-> (&b_drv));

   // R8
   tm_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_mode |-> (b_out == tst_b_val && a_drv == tst_a_drv));

endmodule

// File: rtl/bidir_store_xcvr.sv
module bidir_store_xcvr #(
   parameter int LANE_W = 9,
   parameter int LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANE_W*LANES-1:0] a_in,
   input  logic [LANE_W*LANES-1:0] b_in,
   input  logic [LANES-1:0]        oeab_n,
   input  logic [LANES-1:0]        oeba_n,
   input  logic [LANES-1:0]        leab,
   input  logic [LANES-1:0]        leba,
   input  logic [LANES-1:0]        clkab,
   input  logic [LANES-1:0]        clkba,
   input  logic                    test_mode,
   input  logic [LANE_W*LANES-1:0] tst_a_val,
   input  logic [LANE_W*LANES-1:0] tst_a_drv,
   input  logic [LANE_W*LANES-1:0] tst_b_val,
   input  logic [LANE_W*LANES-1:0] tst_b_drv,
   output logic [LANE_W*LANES-1:0] a_out,
   output logic [LANE_W*LANES-1:0] a_drv,
   output logic [LANE_W*LANES-1:0] b_out,
   output logic [LANE_W*LANES-1:0] b_drv
);

   localparam int TOTAL_W = LANE_W * LANES;

   if (LANE_W < 1) begin : g_bad_width
      $error("LANE_W must be at least 1");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (TOTAL_W > 1024) begin : g_bad_total
      $error("total width too large");
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      bsx_lane #(.LW(LANE_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .a_in      (a_in[k*LANE_W +: LANE_W]),
         .b_in      (b_in[k*LANE_W +: LANE_W]),
         .oeab_n    (oeab_n[k]),
         .oeba_n    (oeba_n[k]),
         .leab      (leab[k]),
         .leba      (leba[k]),
         .clkab     (clkab[k]),
         .clkba     (clkba[k]),
         .test_mode (test_mode),
         .tst_a_val (tst_a_val[k*LANE_W +: LANE_W]),
         .tst_a_drv (tst_a_drv[k*LANE_W +: LANE_W]),
         .tst_b_val (tst_b_val[k*LANE_W +: LANE_W]),
         .tst_b_drv (tst_b_drv[k*LANE_W +: LANE_W]),
         .a_out     (a_out[k*LANE_W +: LANE_W]),
         .a_drv     (a_drv[k*LANE_W +: LANE_W]),
         .b_out     (b_out[k*LANE_W +: LANE_W]),
         .b_drv     (b_drv[k*LANE_W +: LANE_W])
      );
   end

endmodule

// File: tb/bidir_store_xcvr_test.sv
module bidir_store_xcvr_test;

   localparam int CLK_P = 10;
   localparam int LW    = 9;
   localparam int NL    = 2;
   localparam int W     = LW * NL;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [W-1:0]  a_in, b_in, tst_a_val, tst_a_drv, tst_b_val, tst_b_drv;
   logic [NL-1:0] oeab_n, oeba_n, leab, leba, clkab, clkba;
   logic          test_mode;
   logic [W-1:0]  a_out, a_drv, b_out, b_drv;

   int n_chk  = 0;
   int n_fail = 0;

   logic [LW-1:0] st_ab [NL];
   logic [LW-1:0] st_ba [NL];
   logic          p_ab  [NL];
   logic          p_ba  [NL];

   always #(CLK_P/2) clk = ~clk;

   bidir_store_xcvr #(.LANE_W(LW), .LANES(NL)) uut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
      .oeab_n(oeab_n), .oeba_n(oeba_n), .leab(leab), .leba(leba),
      .clkab(clkab), .clkba(clkba), .test_mode(test_mode),
      .tst_a_val(tst_a_val), .tst_a_drv(tst_a_drv),
      .tst_b_val(tst_b_val), .tst_b_drv(tst_b_drv),
      .a_out(a_out), .a_drv(a_drv), .b_out(b_out), .b_drv(b_drv)
   );

   function automatic logic [W-1:0] exp_b_val();
      logic [W-1:0] r;
      for (int l = 0; l < NL; l++)
         r[l*LW +: LW] = test_mode ? tst_b_val[l*LW +: LW] :
                         (leab[l] ? a_in[l*LW +: LW] : st_ab[l]);
      return r;
   endfunction

   function automatic logic [W-1:0] exp_a_val();
      logic [W-1:0] r;
      for (int l = 0; l < NL; l++)
         r[l*LW +: LW] = test_mode ? tst_a_val[l*LW +: LW] :
                         (leba[l] ? b_in[l*LW +: LW] : st_ba[l]);
      return r;
   endfunction

   function automatic logic [W-1:0] exp_drv(input logic [NL-1:0] oe_n,
                                            input logic [W-1:0] tdrv);
      logic [W-1:0] r;
      for (int l = 0; l < NL; l++)
         r[l*LW +: LW] = test_mode ? tdrv[l*LW +: LW] : {LW{~oe_n[l]}};
      return r;
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int l = 0; l < NL; l++) begin
         st_ab[l] = '0; st_ba[l] = '0; p_ab[l] = 1'b0; p_ba[l] = 1'b0;
      end
   endtask

   // Compare the outputs, then advance one clk edge in the model, ending at negedge.
   task automatic tick(input string tag_b, input string tag_a);
      #2;
      chk(tag_b, b_out, exp_b_val());
      chk(tag_a, a_out, exp_a_val());
      chk("R5 b_drv", b_drv, exp_drv(oeab_n, tst_b_drv));
      chk("R5 a_drv", a_drv, exp_drv(oeba_n, tst_a_drv));
      @(posedge clk);
      for (int l = 0; l < NL; l++) begin
         if (!test_mode && (leab[l] || (clkab[l] && !p_ab[l])))
            st_ab[l] = a_in[l*LW +: LW];
         if (!test_mode && (leba[l] || (clkba[l] && !p_ba[l])))
            st_ba[l] = b_in[l*LW +: LW];
         p_ab[l] = clkab[l];
         p_ba[l] = clkba[l];
      end
      @(negedge clk);
   endtask

   task automatic tick_auto();
      string tb, ta;
      tb = test_mode ? "R8 b_out" : ((|leab) ? "R1 b_out" : "R3 b_out");
      ta = test_mode ? "R8 a_out" : "R6 a_out";
      tick(tb, ta);
   endtask

   task automatic idle_inputs();
      a_in = '0; b_in = '0; tst_a_val = '0; tst_a_drv = '0;
      tst_b_val = '0; tst_b_drv = '0; oeab_n = '0; oeba_n = '0;
      leab = '0; leba = '0; clkab = '0; clkba = '0; test_mode = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int seed_v;
      seed_v = $urandom(32'd20240611);
      idle_inputs();
      rst_n = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: storage cleared, outputs zero with latches closed
      a_in = 18'h3ffff; b_in = 18'h2aaaa;
      #2;
      chk("R9 b_out after reset", b_out, '0);
      chk("R9 a_out after reset", a_out, '0);
      tick("R9 b_out", "R9 a_out");

      // R3: capture on rising clkab, lane 0 only
      a_in = 18'h0_0155; clkab = 2'b01;
      tick("R3 b_out", "R6 a_out");
      #2 chk("R3 captured lane0", b_out, 18'h0_0155);
      // R2: clock stays high, data changes, output holds
      a_in = 18'h0_00aa;
      tick("R2 b_out", "R6 a_out");
      #2 chk("R2 hold high", b_out, 18'h0_0155);
      clkab = 2'b00; a_in = 18'h0_0033;
      tick("R2 b_out", "R6 a_out");
      #2 chk("R2 hold low", b_out, 18'h0_0155);

      // R4: transparent, extra clock rise, then latch closes
      leab = 2'b01; a_in = 18'h0_0111;
      tick("R1 b_out", "R6 a_out");
      a_in = 18'h0_0122; clkab = 2'b01;
      tick("R4 b_out", "R6 a_out");
      leab = 2'b00; a_in = 18'h0_01ee;
      #2 chk("R4 last transparent value", b_out, 18'h0_0122);
      tick("R4 b_out", "R6 a_out");
      clkab = 2'b00;

      // R7: lane 1 transparent, lane 0 holds
      leab = 2'b10; a_in = {9'h1c3, 9'h0f0};
      #2 chk("R7 lane split", b_out, {9'h1c3, 9'h122});
      tick("R7 b_out", "R6 a_out");
      leab = 2'b00;

      // R6: B-to-A capture on lane 1
      b_in = {9'h155, 9'h000}; clkba = 2'b10;
      tick("R6 a_out", "R6 a_out");
      #2 chk("R6 captured lane1", a_out, {9'h155, 9'h000});
      clkba = 2'b00;
      oeba_n = 2'b01;
      #2 chk("R5 a_drv lane0 off", a_drv, {9'h1ff, 9'h000});
      tick("R6 a_out", "R6 a_out");

      // R8: override, capture edge ignored, value returns after
      test_mode = 1'b1; tst_b_val = 18'h2_5a5a; tst_b_drv = 18'h1_0f0f;
      a_in = 18'h3_ffff; leab = 2'b11;
      #2 chk("R8 override value", b_out, 18'h2_5a5a);
      chk("R8 override drive", b_drv, 18'h1_0f0f);
      tick("R8 b_out", "R8 a_out");
      leab = 2'b00; clkab = 2'b11;
      tick("R8 b_out", "R8 a_out");
      test_mode = 1'b0; clkab = 2'b11;
      #2 chk("R8 storage frozen", b_out, {9'h1c3, 9'h122});
      tick("R8 b_out", "R6 a_out");
      clkab = 2'b00;
      tick_auto();

      // Random traffic with coincident control changes
      for (int i = 0; i < 3000; i++) begin
         a_in = W'($urandom); b_in = W'($urandom);
         tst_a_val = W'($urandom); tst_a_drv = W'($urandom);
         tst_b_val = W'($urandom); tst_b_drv = W'($urandom);
         oeab_n = NL'($urandom); oeba_n = NL'($urandom);
         for (int l = 0; l < NL; l++) begin
            leab[l] = ($urandom % 4) == 0;
            leba[l] = ($urandom % 4) == 0;
         end
         clkab = NL'($urandom); clkba = NL'($urandom);
         test_mode = ($urandom % 12) == 0;
         tick_auto();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule